// File: doc/BRIEF.md
# BPSK Quadrature Phase Modulator

This block is the phase half of a quadrature direct digital synthesizer that can key its output between two phase offsets. A 48-bit accumulator advances every clock by a carrier tuning word. The top 14 bits of the accumulator are added to one of two stored 14-bit phase offsets. The result is presented as an in-phase phase index. A second index sits a quarter turn ahead for the quadrature path. Both indices get the same offset, so a symbol flip rotates I and Q together.

The offset is picked by a one-bit modulation input. That input comes from an asynchronous data source, so it is synchronized before use. A mode input switches to plain tone operation. In that mode the modulation input is ignored and the first offset is always used, so software can step through arbitrary phases by rewriting that offset. Software writes the tuning word and the offsets into staging registers. An update pulse then copies all of them into the working set in one cycle, so a new carrier and new offsets take effect together. Amplitude lookup and conversion to analog are handled downstream.

Top module: `bpsk_quad_phase`

## Requirements
- R1: While rst_ni is low, the accumulator, the staging registers, the working registers and both phase outputs are zero.
- R2: A write with wr_en_i high loads staging only. Address 0 takes the full 48-bit wr_data_i as the tuning word. Address 1 takes wr_data_i[13:0] as offset A. Address 2 takes wr_data_i[13:0] as offset B. A write to address 3 changes nothing.
- R3: Staged values do not reach the outputs until update_i is high at a clock edge. That edge copies all staging registers into the working set. The phase outputs show the new values from the following edge on.
- R4: Every clock, the accumulator adds the working tuning word, modulo 2^48.
- R5: On each edge, i_phase_o is registered as accumulator bits [47:34] plus the selected offset, modulo 2^14.
- R6: On every cycle after reset, q_phase_o equals i_phase_o + 4096 modulo 2^14, which is a quarter cycle.
- R7: With single_tone_i low, synchronized bpsk_i low selects offset A, and synchronized bpsk_i high selects offset B.
- R8: bpsk_i passes through two flops. A change set up before edge E appears on i_phase_o after edge E+2.
- R9: With single_tone_i high, bpsk_i is ignored and offset A is always applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register select: 0 tuning word, 1 offset A, 2 offset B |
| wr_data_i | input | 48 | Write data |
| update_i | input | 1 | Copies the staging registers into the working set |
| bpsk_i | input | 1 | Asynchronous modulation bit |
| single_tone_i | input | 1 | Ignores bpsk_i and forces offset A |
| i_phase_o | output | 14 | In-phase phase index |
| q_phase_o | output | 14 | Quadrature phase index, I plus a quarter turn |

## Verification
The bench targets the following faults:
- **Offset wrap.** Offsets near full scale must wrap modulo 2^14 on both paths. A Q adder that is one bit too wide, or that misses the carry, shows a wrong Q value near zero.
- **Synchronizer latency.** This is checked at each edge. A missing or extra flop moves the symbol switch by one cycle.
- **Staging and update.** Staged writes are checked to be invisible before the update pulse and visible exactly one edge after it. A design that writes straight through to the working set fails here.
- **Ignored inputs.** Both the unused address and tone mode are checked at the outputs. So is the accumulator step, over a full 2^14 wrap and with a fractional tuning word whose carries come up from the low bits.

// File: rtl/bpsk_pkg.sv
package bpsk_pkg;
  typedef enum logic [1:0] {
    ADDR_FTW   = 2'd0,
    ADDR_OFF_A = 2'd1,
    ADDR_OFF_B = 2'd2,
    ADDR_NONE  = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/bpsk_regs.sv
module bpsk_regs
  import bpsk_pkg::*;
#(
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [ACC_W-1:0]   wr_data_i,
  input  logic               update_i,
  output logic [ACC_W-1:0]   ftw_o,
  output logic [PHASE_W-1:0] off_a_o,
  output logic [PHASE_W-1:0] off_b_o
);
  logic [ACC_W-1:0]   ftw_s;
  logic [PHASE_W-1:0] off_a_s, off_b_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_s   <= '0;
      off_a_s <= '0;
      off_b_s <= '0;
    end else if (wr_en_i) begin
      case (wr_addr_i)
        ADDR_FTW:   ftw_s   <= wr_data_i;
        ADDR_OFF_A: off_a_s <= wr_data_i[PHASE_W-1:0];
        ADDR_OFF_B: off_b_s <= wr_data_i[PHASE_W-1:0];
        default: ;
      endcase
    end
  end

  // working set swaps atomically
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ftw_o   <= '0;
      off_a_o <= '0;
      off_b_o <= '0;
    end else if (update_i) begin
      ftw_o   <= ftw_s;
      off_a_o <= off_a_s;
      off_b_o <= off_b_s;
    end
  end

  AST_ACTIVE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !update_i |=> ($stable(ftw_o) && $stable(off_a_o) && $stable(off_b_o))); // R3
endmodule

// File: rtl/bpsk_sync.sv
module bpsk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];

  generate
    if (STAGES == 2) begin : g_chk
      AST_SYNC_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(q_o) |-> $past(d_i, 2)); // R8
    end
  endgenerate
endmodule

// File: rtl/bpsk_phase_core.sv
module bpsk_phase_core #(
  parameter int ACC_W   = 48,
  parameter int PHASE_W = 14
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [ACC_W-1:0]   ftw_i,
  input  logic [PHASE_W-1:0] off_a_i,
  input  logic [PHASE_W-1:0] off_b_i,
  input  logic               sel_b_i,
  output logic [PHASE_W-1:0] i_phase_o,
  output logic [PHASE_W-1:0] q_phase_o
);
  localparam logic [PHASE_W-1:0] QUARTER = {2'b01, {(PHASE_W-2){1'b0}}};

  logic [ACC_W-1:0]   acc_q;
  logic [PHASE_W-1:0] offset, phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) acc_q <= '0;
    else         acc_q <= acc_q + ftw_i;
  end

  assign offset  = sel_b_i ? off_b_i : off_a_i;
  assign phase_i = acc_q[ACC_W-1 -: PHASE_W] + offset;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      i_phase_o <= '0;
      q_phase_o <= '0;
    end else begin
      i_phase_o <= phase_i;
      q_phase_o <= phase_i + QUARTER;
    end
  end

  AST_ACC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> acc_q == $past(acc_q) + $past(ftw_i)); // R4
  AST_QUAD_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> q_phase_o == i_phase_o + QUARTER); // R6
endmodule

// File: rtl/bpsk_quad_phase.sv
module bpsk_quad_phase #(
  parameter int ACC_W       = 48,
  parameter int PHASE_W     = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_en_i,
  input  logic [1:0]         wr_addr_i,
  input  logic [ACC_W-1:0]   wr_data_i,
  input  logic               update_i,
  input  logic               bpsk_i,
  input  logic               single_tone_i,
  output logic [PHASE_W-1:0] i_phase_o,
  output logic [PHASE_W-1:0] q_phase_o
);
  logic [ACC_W-1:0]   ftw;
  logic [PHASE_W-1:0] off_a, off_b;
  logic               bpsk_s, sel_b;

  bpsk_regs #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i, .update_i,
    .ftw_o(ftw), .off_a_o(off_a), .off_b_o(off_b)
  );

  bpsk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(bpsk_i), .q_o(bpsk_s)
  );

  assign sel_b = bpsk_s & ~single_tone_i;

  bpsk_phase_core #(.ACC_W(ACC_W), .PHASE_W(PHASE_W)) u_core (
    .clk_i, .rst_ni, .ftw_i(ftw), .off_a_i(off_a), .off_b_i(off_b),
    .sel_b_i(sel_b), .i_phase_o, .q_phase_o
  );

  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (i_phase_o == '0 && q_phase_o == '0)); // R1
endmodule

// File: tb/bpsk_quad_phase_test.sv
module bpsk_quad_phase_test;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 6;

  localparam logic [13:0] V_A   [NV] = '{14'h0100, 14'h0100, 14'h3FFF, 14'h3FFF, 14'h0005, 14'h0AAA};
  localparam logic [13:0] V_B   [NV] = '{14'h2100, 14'h2100, 14'h1234, 14'h1234, 14'h3000, 14'h1555};
  localparam logic        V_BIT [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam logic        V_TONE[NV] = '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0};
  localparam logic [13:0] V_EXP [NV] = '{14'h0100, 14'h2100, 14'h3FFF, 14'h3FFF, 14'h3000, 14'h0AAA};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [47:0] wr_data = '0;
  logic        update = 1'b0;
  logic        bpsk = 1'b0;
  logic        tone = 1'b0;
  logic [13:0] i_ph, q_ph;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bpsk_quad_phase uut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .update_i(update), .bpsk_i(bpsk),
    .single_tone_i(tone), .i_phase_o(i_ph), .q_phase_o(q_ph)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [47:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic upd();
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    logic [13:0] p0, p1;
    int bad;
    #1;
    chk("R1 reset i", 32'(i_ph), 0);
    chk("R1 reset q", 32'(q_ph), 0);
    wait_cyc(2);
    rst_n = 1'b1;
    wait_cyc(2);
    chk("R6 q after reset", 32'(q_ph), 32'h1000);

    // vector table, accumulator held at zero (tuning word 0)
    for (int v = 0; v < NV; v++) begin
      wr(2'd1, 48'(V_A[v]));
      wr(2'd2, 48'(V_B[v]));
      upd();
      bpsk = V_BIT[v];
      tone = V_TONE[v];
      wait_cyc(4);
      chk("R5/R7/R9 vector i", 32'(i_ph), 32'(V_EXP[v]));
      chk("R6 vector q", 32'(q_ph), 32'(14'(V_EXP[v] + 14'h1000)));
    end

    // R8 synchronizer latency: state A=0AAA B=1555, bpsk 0
    bpsk = 1'b1;
    @(negedge clk); chk("R8 after 1 edge", 32'(i_ph), 32'h0AAA);
    @(negedge clk); chk("R8 after 2 edges", 32'(i_ph), 32'h0AAA);
    @(negedge clk); chk("R8 after 3 edges", 32'(i_ph), 32'h1555);

    // R3 staging not visible before update
    wr(2'd2, 48'h0777);
    wait_cyc(2);
    chk("R3 staged hidden", 32'(i_ph), 32'h1555);
    update = 1'b1;
    @(negedge clk);
    update = 1'b0;
    chk("R3 one edge after update", 32'(i_ph), 32'h1555);
    @(negedge clk);
    chk("R3 two edges after update", 32'(i_ph), 32'h0777);

    // R2 address 3 ignored
    wr(2'd3, 48'hFFFF_FFFF_FFFF);
    upd();
    wait_cyc(3);
    chk("R2 addr3 ignored", 32'(i_ph), 32'h0777);

    // R4 integer step of 3 through a full wrap
    bpsk = 1'b0;
    wr(2'd1, 48'h0);
    wr(2'd0, 48'h3 << 34);
    upd();
    wait_cyc(3);
    bad = 0;
    p0 = i_ph;
    for (int k = 0; k < 6000; k++) begin
      @(negedge clk);
      p1 = i_ph;
      if (14'(p1 - p0) != 14'd3) bad++;
      if (q_ph != 14'(p1 + 14'h1000)) bad++;
      p0 = p1;
    end
    chk("R4 step 3 with wrap, R6 on the way", 32'(bad), 0);

    // R4 fractional step: half a phase unit per cycle
    wr(2'd0, 48'h1 << 33);
    upd();
    wait_cyc(3);
    p0 = i_ph;
    wait_cyc(8);
    chk("R4 fractional step", 32'(14'(i_ph - p0)), 4);

    // R1 reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 async reset i", 32'(i_ph), 0);
    chk("R1 async reset q", 32'(q_ph), 0);
    @(negedge clk);
    rst_n = 1'b1;
    wait_cyc(5);
    chk("R1 tuning word cleared", 32'(i_ph), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule